// File: doc/BRIEF.md
# Virtualized Time Counter Register Port

This block serves the time counter registers of a 32-bit core that can run guests. The platform supplies a free-running 64-bit time value and a flag telling whether a time source is present. The block keeps a 64-bit offset that the hypervisor programs, and reads it back, through two 32-bit register halves. When the core runs virtualized, a read of the time registers returns the platform time plus that offset. Otherwise it returns the platform time unchanged.

Access is a single-cycle register port. Each cycle the core presents an enable, a 2-bit selector, a write flag and write data. Read data and an error flag come back combinationally in the same cycle. A write to an offset half takes effect at the next rising clock edge. Selector codes: 0 = time bits [31:0], 1 = time bits [63:32], 2 = offset bits [31:0], 3 = offset bits [63:32].

Top module: `vtime_csr`

## Requirements
- R1: Synchronous active-high reset clears the 64-bit offset to zero, so both offset halves read 0 after reset.
- R2: With the virtualization input low, reading selector 0 returns platform time bits [31:0].
- R3: With the virtualization input high, reading selector 0 returns bits [31:0] of platform time plus the offset.
- R4: Reading selector 1 returns bits [63:32] of the same 64-bit value as R2/R3, so a carry out of the low word reaches the high word.
- R5: A write to selector 2 replaces offset bits [31:0] at the next clock edge and leaves bits [63:32] unchanged.
- R6: A write to selector 3 replaces offset bits [63:32] at the next clock edge and leaves bits [31:0] unchanged.
- R7: Reading selector 2 returns offset bits [31:0] and reading selector 3 returns offset bits [63:32]. A write access returns the half's value from before the write.
- R8: While the time-source flag is low, any enabled access raises the error output, returns 0 and leaves the offset unchanged.
- R9: A write to selector 0 or 1 raises the error output, returns 0 and leaves the offset unchanged.
- R10: The sum is a 64-bit add that wraps modulo 2^64.
- R11: With enable low, the error output and read data are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| virt_on | input | 1 | Core currently runs a guest |
| src_present | input | 1 | Platform time source is available |
| plat_time | input | 64 | Platform time value |
| acc_en | input | 1 | Register access valid this cycle |
| acc_sel | input | 2 | Register selector (codes in the description) |
| acc_we | input | 1 | Access is a write |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational |
| acc_err | output | 1 | Access rejected, combinational |

## Verification
The assertions assume that the platform time and the control inputs are stable around the clock edge, and that reset is high at the first edge. The bench drives every input on the falling edge and asserts reset for several cycles before any access. The offset checks that compare the value after an edge with the value before it assume the write data is held for the whole access cycle. The bench keeps each access steady from one falling edge to the next.

// File: rtl/vtime_pkg.sv
package vtime_pkg;

    parameter int unsigned HALF_W = 32;
    localparam int unsigned FULL_W = 2 * HALF_W;

    typedef enum logic [1:0] {
        SEL_TIME_LO  = 2'd0,
        SEL_TIME_HI  = 2'd1,
        SEL_DELTA_LO = 2'd2,
        SEL_DELTA_HI = 2'd3
    } csr_sel_e;

    typedef struct packed {
        logic       err;      // access rejected
        logic [1:0] wr_half;  // offset half write strobes
        logic       rd_time;  // read from time sum, else offset
        logic       upper;    // upper half selected
    } access_t;

    function automatic logic is_time_sel(input csr_sel_e sel);
        return (sel == SEL_TIME_LO) || (sel == SEL_TIME_HI);
    endfunction

endpackage

// File: rtl/vtime_decode.sv
module vtime_decode
    import vtime_pkg::*;
(
    input  logic     acc_en,
    input  csr_sel_e sel,
    input  logic     we,
    input  logic     src_present,
    output access_t  acc
);
    logic reject;

    always_comb begin
        reject = acc_en && (!src_present || (we && is_time_sel(sel)));
        acc.err     = reject;
        acc.rd_time = is_time_sel(sel);
        acc.upper   = (sel == SEL_TIME_HI) || (sel == SEL_DELTA_HI);
        acc.wr_half = 2'b00;
        if (acc_en && we && !reject) begin
            acc.wr_half[0] = (sel == SEL_DELTA_LO);
            acc.wr_half[1] = (sel == SEL_DELTA_HI);
        end
    end
endmodule

// File: rtl/vtime_delta.sv
module vtime_delta #(
    parameter int unsigned HALF_W = 32,
    localparam int unsigned NHALF = 2,
    localparam int unsigned FULL_W = NHALF * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NHALF-1:0]  wr_half,
    input  logic [HALF_W-1:0] wdata,
    output logic [FULL_W-1:0] delta_q
);
    for (genvar h = 0; h < NHALF; h++) begin : g_half
        logic [HALF_W-1:0] half_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                half_q <= '0;
            end else if (wr_half[h]) begin
                half_q <= wdata;
            end
        end
        assign delta_q[h*HALF_W +: HALF_W] = half_q;
    end
endmodule

// File: rtl/vtime_sum.sv
module vtime_sum #(
    parameter int unsigned FULL_W = 64
) (
    input  logic              virt_on,
    input  logic [FULL_W-1:0] plat_time,
    input  logic [FULL_W-1:0] delta,
    output logic [FULL_W-1:0] sum
);
    logic [FULL_W-1:0] addend;

    always_comb begin
        addend = virt_on ? delta : '0;
        sum    = plat_time + addend; // wraps modulo 2^FULL_W
    end
endmodule

// File: rtl/vtime_csr.sv
module vtime_csr
    import vtime_pkg::*;
#(
    parameter int unsigned HW = vtime_pkg::HALF_W,
    localparam int unsigned FW = 2 * HW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          virt_on,
    input  logic          src_present,
    input  logic [FW-1:0] plat_time,
    input  logic          acc_en,
    input  logic [1:0]    acc_sel,
    input  logic          acc_we,
    input  logic [HW-1:0] acc_wdata,
    output logic [HW-1:0] acc_rdata,
    output logic          acc_err
);
    access_t       acc;
    logic [FW-1:0] delta_q;
    logic [FW-1:0] time_sum;
    logic [FW-1:0] rd_word;

    vtime_decode u_decode (
        .acc_en      (acc_en),
        .sel         (csr_sel_e'(acc_sel)),
        .we          (acc_we),
        .src_present (src_present),
        .acc         (acc)
    );

    vtime_delta #(.HALF_W(HW)) u_delta (
        .clk     (clk),
        .rst     (rst),
        .wr_half (acc.wr_half),
        .wdata   (acc_wdata),
        .delta_q (delta_q)
    );

    vtime_sum #(.FULL_W(FW)) u_sum (
        .virt_on   (virt_on),
        .plat_time (plat_time),
        .delta     (delta_q),
        .sum       (time_sum)
    );

    always_comb begin
        rd_word   = acc.rd_time ? time_sum : delta_q;
        acc_err   = acc.err;
        acc_rdata = '0;
        if (acc_en && !acc.err) begin
            acc_rdata = acc.upper ? rd_word[FW-1:HW] : rd_word[HW-1:0];
        end
    end
endmodule

// File: rtl/vtime_csr_chk.sv
module vtime_csr_chk #(
    parameter int unsigned HW = 32,
    localparam int unsigned FW = 2 * HW
) (
    input logic          clk,
    input logic          rst,
    input logic          virt_on,
    input logic          src_present,
    input logic [FW-1:0] plat_time,
    input logic          acc_en,
    input logic [1:0]    acc_sel,
    input logic          acc_we,
    input logic [HW-1:0] acc_wdata,
    input logic [HW-1:0] acc_rdata,
    input logic          acc_err,
    input logic [FW-1:0] delta_q
);
    logic wr_ok;
    assign wr_ok = acc_en && acc_we && src_present && !acc_err;

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> delta_q == '0);

    // R2
    plain_time_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_en && src_present && !acc_we && !virt_on && acc_sel == 2'd0)
        |-> acc_rdata == plat_time[HW-1:0]);

    // R5
    low_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && acc_sel == 2'd2)
        |=> (delta_q[HW-1:0] == $past(acc_wdata)) && $stable(delta_q[FW-1:HW]));

    // R6
    high_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && acc_sel == 2'd3)
        |=> (delta_q[FW-1:HW] == $past(acc_wdata)) && $stable(delta_q[HW-1:0]));

    // R8
    no_source_err_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !src_present) |-> (acc_err && acc_rdata == '0));

    // R8
    no_source_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !src_present) |=> $stable(delta_q));

    // R9
    time_write_err_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_en && acc_we && acc_sel[1] == 1'b0) |-> acc_err);

    // R9
    time_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_en && acc_we && acc_sel[1] == 1'b0) |=> $stable(delta_q));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_en |-> (!acc_err && acc_rdata == '0));
endmodule

bind vtime_csr vtime_csr_chk #(.HW(HW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .virt_on     (virt_on),
    .src_present (src_present),
    .plat_time   (plat_time),
    .acc_en      (acc_en),
    .acc_sel     (acc_sel),
    .acc_we      (acc_we),
    .acc_wdata   (acc_wdata),
    .acc_rdata   (acc_rdata),
    .acc_err     (acc_err),
    .delta_q     (delta_q)
);

// File: tb/test_vtime_csr.sv
`timescale 1ns/1ps
module test_vtime_csr;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        virt_on = 1'b0;
    logic        src_present = 1'b1;
    logic [63:0] plat_time = '0;
    logic        acc_en = 1'b0;
    logic [1:0]  acc_sel = '0;
    logic        acc_we = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_err;

    int vectors = 0;
    int errors  = 0;
    logic [63:0] model_delta = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    vtime_csr i_vtime_csr (
        .clk(clk), .rst(rst), .virt_on(virt_on), .src_present(src_present),
        .plat_time(plat_time), .acc_en(acc_en), .acc_sel(acc_sel),
        .acc_we(acc_we), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_err(acc_err)
    );

    task automatic compare(input logic [31:0] exp_d, input logic exp_e, input string req);
        vectors++;
        if (acc_rdata !== exp_d || acc_err !== exp_e) begin
            errors++;
            $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                     req, acc_rdata, acc_err, exp_d, exp_e);
        end
    endtask

    // One access from falling edge to falling edge; checks the same-cycle response.
    task automatic access(input logic [1:0] sel, input logic we, input logic [31:0] wd,
                          input logic [31:0] exp_d, input logic exp_e, input string req);
        @(negedge clk);
        acc_en = 1'b1; acc_sel = sel; acc_we = we; acc_wdata = wd;
        #1;
        compare(exp_d, exp_e, req);
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    function automatic logic [31:0] exp_time(input logic [63:0] t, input logic v,
                                             input logic hi, input logic [63:0] d);
        logic [63:0] s;
        s = t + (v ? d : 64'd0);
        return hi ? s[63:32] : s[31:0];
    endfunction

    task automatic set_delta(input logic [63:0] d);
        access(2'd2, 1'b1, d[31:0], model_delta[31:0], 1'b0, "R7");
        model_delta[31:0] = d[31:0];
        access(2'd3, 1'b1, d[63:32], model_delta[63:32], 1'b0, "R7");
        model_delta[63:32] = d[63:32];
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: rdata=%h err=%b expected completion", acc_rdata, acc_err);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [63:0] deltas [6];
        logic [63:0] times  [6];
        deltas = '{64'h0, 64'h1, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
                   64'h1234_5678_9ABC_DEF0, 64'h8000_0000_8000_0000};
        times  = '{64'h0, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
                   64'h0000_0001_0000_0000, 64'hDEAD_BEEF_0BAD_F00D, 64'h7FFF_FFFF_8000_0001};
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: offset cleared by reset
        access(2'd2, 1'b0, '0, 32'h0, 1'b0, "R1");
        access(2'd3, 1'b0, '0, 32'h0, 1'b0, "R1");

        // R11: idle port is quiet
        @(negedge clk); plat_time = 64'h5555_AAAA_5555_AAAA; #1;
        compare(32'h0, 1'b0, "R11");

        // Sweep offsets x times x virt x selector: R2 R3 R4 R7 R10
        foreach (deltas[di]) begin
            set_delta(deltas[di]);
            access(2'd2, 1'b0, '0, model_delta[31:0], 1'b0, "R7");
            access(2'd3, 1'b0, '0, model_delta[63:32], 1'b0, "R7");
            foreach (times[ti]) begin
                for (int v = 0; v < 2; v++) begin
                    @(negedge clk);
                    plat_time = times[ti]; virt_on = v[0];
                    access(2'd0, 1'b0, '0, exp_time(times[ti], v[0], 1'b0, model_delta), 1'b0,
                           v ? "R3" : "R2");
                    access(2'd1, 1'b0, '0, exp_time(times[ti], v[0], 1'b1, model_delta), 1'b0,
                           "R4/R10");
                end
            end
        end

        // R5: low write keeps high half
        set_delta(64'hAAAA_BBBB_CCCC_DDDD);
        access(2'd2, 1'b1, 32'h1111_2222, 32'hCCCC_DDDD, 1'b0, "R5");
        model_delta[31:0] = 32'h1111_2222;
        access(2'd3, 1'b0, '0, 32'hAAAA_BBBB, 1'b0, "R5");
        access(2'd2, 1'b0, '0, 32'h1111_2222, 1'b0, "R5");
        // R6: high write keeps low half
        access(2'd3, 1'b1, 32'h3333_4444, 32'hAAAA_BBBB, 1'b0, "R6");
        model_delta[63:32] = 32'h3333_4444;
        access(2'd2, 1'b0, '0, 32'h1111_2222, 1'b0, "R6");
        access(2'd3, 1'b0, '0, 32'h3333_4444, 1'b0, "R6");

        // R9: time halves reject writes, offset untouched
        access(2'd0, 1'b1, 32'hFFFF_FFFF, 32'h0, 1'b1, "R9");
        access(2'd1, 1'b1, 32'hFFFF_FFFF, 32'h0, 1'b1, "R9");
        access(2'd2, 1'b0, '0, model_delta[31:0], 1'b0, "R9");
        access(2'd3, 1'b0, '0, model_delta[63:32], 1'b0, "R9");

        // R8: no time source, every selector errors, writes dropped
        @(negedge clk); src_present = 1'b0;
        for (int s = 0; s < 4; s++) begin
            access(s[1:0], 1'b0, '0, 32'h0, 1'b1, "R8");
            access(s[1:0], 1'b1, 32'h0F0F_0F0F, 32'h0, 1'b1, "R8");
        end
        @(negedge clk); src_present = 1'b1;
        access(2'd2, 1'b0, '0, model_delta[31:0], 1'b0, "R8");
        access(2'd3, 1'b0, '0, model_delta[63:32], 1'b0, "R8");

        // R10: wrap of full sum with carry across words
        set_delta(64'h0000_0000_0000_0002);
        @(negedge clk); plat_time = 64'hFFFF_FFFF_FFFF_FFFF; virt_on = 1'b1;
        access(2'd0, 1'b0, '0, 32'h0000_0001, 1'b0, "R10");
        access(2'd1, 1'b0, '0, 32'h0000_0000, 1'b0, "R10");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule